// File: doc/BRIEF.md
# FPGA Slave-Serial Configuration Loader

The block brings up an SRAM-based FPGA that is configured over a two-wire serial path: a configuration clock and a single data line. One start pulse launches the whole run. The loader first pulses the target's active-low program pin so that its configuration memory is cleared. It then waits for the target's init handshake, shifts a stream of bytes that arrives over a valid/ready port, and waits for the done pin. A few trailing clock pulses finish the target's startup.

Each wait is bounded by a cycle limit set through a parameter. Every wait has its own failure code, so the system can tell whether the target never entered the clearing phase, never left it, or never accepted the image. The first failure ends the run. The status code stays unchanged until the next start. The configuration clock is derived from the system clock by a half-period parameter.

Top module: `fpga_serial_loader`

## Requirements
- R1: After reset `busy_o`=0, `status_o`=0, `prog_o`=1, `cclk_o`=0 and `ready_o`=0.
- R2: A `start_i` seen while idle raises `busy_o` on the next cycle. `prog_o` then stays high for `PRE_CYC` cycles and goes low after that. A `start_i` seen while busy has no effect on the run in progress.
- R3: While `prog_o` is low, `init_i` must go low within `T_INIT_LOW` cycles. If it does not, the run ends with `status_o`=1, and `prog_o` will have been low for exactly `T_INIT_LOW` cycles.
- R4: Once `init_i` is seen low, `prog_o` returns high. `init_i` must then return high within `T_INIT_HIGH` cycles, or the run ends with `status_o`=2.
- R5: The loader accepts exactly `len_i` bytes, sampled at start, one byte per cycle in which `valid_i` and `ready_o` are both high. `ready_o` is high only while the loader waits for the next byte.
- R6: Each byte is sent most significant bit first. `din_o` holds each bit for `HALF` cycles with `cclk_o` low before the rising edge, and it does not change at a rising edge of `cclk_o`. `cclk_o` is high for `HALF` cycles per bit.
- R7: After the last bit is sent, `done_i` must go high within `T_DONE` cycles, or the run ends with `status_o`=3 and no extra clock pulses.
- R8: Once `done_i` is seen, the loader issues exactly `EXTRA_CLK` more rising edges of `cclk_o`. It then ends the run with `status_o`=0.
- R9: When `len_i` is 0, the loader goes from the init-high step straight to the wait for done.
- R10: When a run ends, `busy_o` falls and `prog_o` is high. `status_o` holds its code until the next accepted start, and `cclk_o` stays low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a configuration run (acted on only while idle) |
| len_i | input | LEN_W | Number of image bytes, sampled at start |
| data_i | input | 8 | Image byte |
| valid_i | input | 1 | `data_i` holds a byte |
| ready_o | output | 1 | Loader takes the byte this cycle if `valid_i` is high |
| prog_o | output | 1 | Program pin to target, active low |
| cclk_o | output | 1 | Configuration clock to target |
| din_o | output | 1 | Configuration data to target |
| init_i | input | 1 | Init pin from target |
| done_i | input | 1 | Done pin from target |
| busy_o | output | 1 | Run in progress |
| status_o | output | 2 | 0 ok, 1 init-low timeout, 2 init-high timeout, 3 done timeout |

## Verification
The bench builds the loader with a half period of 2 cycles, a 3-cycle program lead-in, 4 trailing clocks and timeout limits of 16 to 24 cycles. With limits this short, each of the three failure paths finishes within a few dozen cycles. The exact number of cycles that the program pin stays low on an init-low failure can then be counted directly. A behavioural target model answers with chosen delays or never answers. It rebuilds the bytes from the rising clock edges, so bit order, byte count, zero-length images and the trailing pulse count are all compared at the pins.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_PLOW, ST_PHIGH, ST_LOAD, ST_SHIFT, ST_WDONE, ST_TAIL
  } fsl_state_e;

  typedef enum logic [1:0] {
    STAT_OK        = 2'd0,
    STAT_INIT_LOW  = 2'd1,
    STAT_INIT_HIGH = 2'd2,
    STAT_DONE      = 2'd3
  } fsl_status_e;
endpackage

// File: rtl/fsl_timer.sv
module fsl_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (clr_i)             cnt_o <= '0;
    else if (cnt_o != {W{1'b1}}) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/fsl_shifter.sv
module fsl_shifter #(
  parameter int HALF = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic [3:0] nbits_i,
  output logic       cclk_o,
  output logic       din_o,
  output logic       done_o
);
  localparam int HCW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HCW-1:0] HLAST = HCW'(HALF - 1);

  logic [7:0]     sh_q;
  logic [3:0]     bits_q;
  logic [HCW-1:0] hcnt_q;
  logic           phase_q, act_q;

  // last high half of the last bit
  assign done_o = act_q && phase_q && (hcnt_q == HLAST) && (bits_q == 4'd1);
  assign cclk_o = act_q && phase_q;
  assign din_o  = sh_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; bits_q <= '0; hcnt_q <= '0; phase_q <= 1'b0; act_q <= 1'b0;
    end else if (load_i) begin
      sh_q <= data_i; bits_q <= nbits_i; hcnt_q <= '0; phase_q <= 1'b0; act_q <= 1'b1;
    end else if (act_q) begin
      if (hcnt_q == HLAST) begin
        hcnt_q <= '0;
        if (!phase_q) begin
          phase_q <= 1'b1;
        end else begin
          phase_q <= 1'b0;
          sh_q    <= {sh_q[6:0], 1'b1};
          bits_q  <= bits_q - 1'b1;
          if (bits_q == 4'd1) act_q <= 1'b0;
        end
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpga_serial_loader.sv
module fpga_serial_loader
  import fsl_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int HALF        = 2,
  parameter int PRE_CYC     = 4,
  parameter int T_INIT_LOW  = 1000,
  parameter int T_INIT_HIGH = 1000,
  parameter int T_DONE      = 1000,
  parameter int EXTRA_CLK   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       data_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             prog_o,
  output logic             cclk_o,
  output logic             din_o,
  input  logic             init_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic [1:0]       status_o
);
  localparam int M1   = (T_INIT_LOW > T_INIT_HIGH) ? T_INIT_LOW : T_INIT_HIGH;
  localparam int M2   = (M1 > T_DONE) ? M1 : T_DONE;
  localparam int MAXL = (M2 > PRE_CYC) ? M2 : PRE_CYC;
  localparam int TW   = $clog2(MAXL + 1);
  localparam logic [TW-1:0] L_PRE  = TW'(PRE_CYC - 1);
  localparam logic [TW-1:0] L_ILOW = TW'(T_INIT_LOW - 1);
  localparam logic [TW-1:0] L_IHI  = TW'(T_INIT_HIGH - 1);
  localparam logic [TW-1:0] L_DONE = TW'(T_DONE - 1);

  fsl_state_e       state_q, state_d;
  fsl_status_e      stat_q, stat_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [TW-1:0]    tcnt;
  logic             tclr, sh_load, sh_done;
  logic [7:0]       sh_data;
  logic [3:0]       sh_nbits;

  always_comb begin
    state_d = state_q;
    stat_d  = stat_q;
    rem_d   = rem_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_PRE; stat_d = STAT_OK; rem_d = len_i;
      end
      ST_PRE: if (tcnt == L_PRE) state_d = ST_PLOW;
      ST_PLOW:
        if (!init_i)              state_d = ST_PHIGH;
        else if (tcnt == L_ILOW) begin state_d = ST_IDLE; stat_d = STAT_INIT_LOW; end
      ST_PHIGH:
        if (init_i)              state_d = (rem_q == '0) ? ST_WDONE : ST_LOAD;
        else if (tcnt == L_IHI) begin state_d = ST_IDLE; stat_d = STAT_INIT_HIGH; end
      ST_LOAD: if (valid_i) begin
        state_d = ST_SHIFT; rem_d = rem_q - 1'b1;
      end
      ST_SHIFT: if (sh_done) state_d = (rem_q == '0) ? ST_WDONE : ST_LOAD;
      ST_WDONE:
        if (done_i)               state_d = ST_TAIL;
        else if (tcnt == L_DONE) begin state_d = ST_IDLE; stat_d = STAT_DONE; end
      ST_TAIL: if (sh_done) begin state_d = ST_IDLE; stat_d = STAT_OK; end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; stat_q <= STAT_OK; rem_q <= '0;
    end else begin
      state_q <= state_d; stat_q <= stat_d; rem_q <= rem_d;
    end
  end

  assign tclr = (state_d != state_q) || (state_q == ST_IDLE);

  fsl_timer #(.W(TW)) i_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(tclr), .cnt_o(tcnt)
  );

  // byte load from stream, or trailing startup pulses once done is seen
  assign sh_load  = ((state_q == ST_LOAD) && valid_i) || ((state_q == ST_WDONE) && done_i);
  assign sh_data  = (state_q == ST_LOAD) ? data_i : 8'hFF;
  assign sh_nbits = (state_q == ST_LOAD) ? 4'd8 : 4'(EXTRA_CLK);

  fsl_shifter #(.HALF(HALF)) i_shifter (
    .clk_i  (clk_i),  .rst_ni (rst_ni),
    .load_i (sh_load), .data_i (sh_data), .nbits_i(sh_nbits),
    .cclk_o (cclk_o), .din_o  (din_o),  .done_o (sh_done)
  );

  assign ready_o  = (state_q == ST_LOAD);
  assign prog_o   = (state_q != ST_PLOW);
  assign busy_o   = (state_q != ST_IDLE);
  assign status_o = stat_q;
endmodule

// File: rtl/fsl_checker.sv
module fsl_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       ready_o,
  input logic       prog_o,
  input logic       cclk_o,
  input logic       din_o,
  input logic       busy_o,
  input logic [1:0] status_o
);
  a_r5_ready_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> busy_o);
  a_r6_din_stable_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cclk_o) |-> $stable(din_o));
  a_r10_cclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cclk_o);
  a_r10_prog_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> prog_o);
  a_r10_status_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(status_o));
  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && prog_o));
endmodule

bind fpga_serial_loader fsl_checker i_fsl_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ready_o(ready_o),
  .prog_o(prog_o), .cclk_o(cclk_o), .din_o(din_o), .busy_o(busy_o),
  .status_o(status_o)
);

// File: tb/test_fpga_serial_loader.sv
module test_fpga_serial_loader;
  localparam int LEN_W = 8, HALF = 2, PRE = 3, TIL = 20, TIH = 24, TDN = 16, EXTRA = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, valid = 1'b0, init = 1'b1, done = 1'b0;
  logic [LEN_W-1:0] len = '0;
  logic [7:0] data = '0;
  logic ready, prog, cclk, din, busy;
  logic [1:0] status;

  always #5 clk = ~clk;

  fpga_serial_loader #(.LEN_W(LEN_W), .HALF(HALF), .PRE_CYC(PRE), .T_INIT_LOW(TIL),
    .T_INIT_HIGH(TIH), .T_DONE(TDN), .EXTRA_CLK(EXTRA)) i_fpga_serial_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len), .data_i(data),
    .valid_i(valid), .ready_o(ready), .prog_o(prog), .cclk_o(cclk), .din_o(din),
    .init_i(init), .done_i(done), .busy_o(busy), .status_o(status));

  int checks = 0, errors = 0;
  bit finished = 0;

  // target model settings (-1 = never answers)
  int d_init = 1, d_high = 1, d_done = 1, exp_bits = 0;
  logic [7:0] tx [16];
  logic [7:0] rx [16];
  int tx_n = 0, tx_idx = 0, rises = 0, cap = 0, lo_cnt = 0, lo_max = 0, hi_cnt = 0, dn_cnt = 0;
  bit pend = 0;
  logic cclk_prev = 1'b0;
  logic [7:0] rx_sh = '0;

  always @(negedge clk) begin
    if (start && !busy) begin
      rises = 0; cap = 0; lo_cnt = 0; lo_max = 0; hi_cnt = 0; dn_cnt = 0;
      done = 1'b0; init = 1'b1; tx_idx = 0; pend = 0;
    end
    if (!prog) begin
      lo_cnt++; if (lo_cnt > lo_max) lo_max = lo_cnt;
      hi_cnt = 0; done = 1'b0;
      if (d_init >= 0 && lo_cnt >= d_init) init = 1'b0;
    end else begin
      lo_cnt = 0;
      if (!init) begin
        hi_cnt++;
        if (d_high >= 0 && hi_cnt >= d_high) init = 1'b1;
      end
      if (cclk && !cclk_prev) begin
        rises++;
        if (cap < exp_bits) begin
          rx_sh = {rx_sh[6:0], din};
          cap++;
          if (cap % 8 == 0) rx[cap/8 - 1] = rx_sh;
        end
      end
      if (init && busy && cap >= exp_bits && d_done >= 0) begin
        dn_cnt++;
        if (dn_cnt >= d_done) done = 1'b1;
      end
    end
    cclk_prev = cclk;
    // byte source
    if (pend) tx_idx++;
    valid = (tx_idx < tx_n);
    data  = tx[tx_idx % 16];
    pend  = valid && ready;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go(input int n);
    len = LEN_W'(n); tx_n = n; exp_bits = 8 * n;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  // len, init delay, init-high delay, done delay, expected status
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{3,  2,  3,  2, 0},
    '{1,  1,  1,  1, 0},
    '{2, -1,  2,  2, 1},
    '{2,  2, -1,  2, 2},
    '{2,  2,  2, -1, 3},
    '{0,  2,  2,  1, 0}
  };

  initial begin
    for (int i = 0; i < 16; i++) tx[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(status == 2'd0, "R1 status", status, 0);
    chk(prog == 1'b1, "R1 prog", prog, 1);
    chk(cclk == 1'b0, "R1 cclk", cclk, 0);
    chk(ready == 1'b0, "R1 ready", ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < 16; i++) tx[i] = 8'((v * 37 + i * 91 + 5) ^ (i == 0 ? 8'h80 : 8'h01));
      d_init = VEC[v][1]; d_high = VEC[v][2]; d_done = VEC[v][3];
      go(VEC[v][0]);
      wait_idle();
      chk(status == 2'(VEC[v][4]), "R3 R4 R7 R8 status", status, VEC[v][4]);
      chk(prog == 1'b1 && !busy, "R10 end state", prog, 1);
      case (VEC[v][4])
        0: begin
          chk(rises == 8 * VEC[v][0] + EXTRA, "R8 R9 rising edges", rises, 8 * VEC[v][0] + EXTRA);
          chk(tx_idx == VEC[v][0], "R5 bytes taken", tx_idx, VEC[v][0]);
          for (int b = 0; b < VEC[v][0]; b++)
            chk(rx[b] == tx[b], "R6 byte msb first", rx[b], tx[b]);
        end
        1: begin
          chk(lo_max == TIL, "R3 prog low cycles", lo_max, TIL);
          chk(rises == 0, "R3 no clocks", rises, 0);
        end
        2: chk(rises == 0 && tx_idx == 0, "R4 no data", rises, 0);
        3: chk(rises == 8 * VEC[v][0], "R7 no extra clocks", rises, 8 * VEC[v][0]);
        default: ;
      endcase
      repeat (3) @(negedge clk);
    end

    // R10 status held while idle after a done timeout
    d_init = 2; d_high = 2; d_done = -1;
    go(1); wait_idle();
    repeat (20) @(negedge clk);
    chk(status == 2'd3, "R10 status held", status, 3);
    chk(cclk == 1'b0 && ready == 1'b0, "R10 idle pins", cclk, 0);

    // R2 program lead-in: high for PRE cycles, then low
    d_init = 5; d_high = 2; d_done = 1;
    for (int i = 0; i < 16; i++) tx[i] = 8'hA5;
    len = 2; tx_n = 2; exp_bits = 16;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1 && prog == 1'b1, "R2 busy and prog high", prog, 1);
    repeat (PRE - 1) @(negedge clk);
    chk(prog == 1'b1, "R2 prog still high", prog, 1);
    @(negedge clk);
    chk(prog == 1'b0, "R2 prog low", prog, 0);
    // R2 start while busy ignored
    for (int i = 0; i < 400 && cap < 4; i++) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_idle();
    chk(status == 2'd0, "R2 restart ignored status", status, 0);
    chk(rises == 16 + EXTRA, "R2 restart ignored edges", rises, 16 + EXTRA);
    chk(rx[0] == 8'hA5 && rx[1] == 8'hA5, "R6 repeated byte", rx[1], 8'hA5);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule